// File: doc/BRIEF.md
# Selectable-Length Timer and Event Counter

This block is a cyclic counter that runs in the system clock domain and advances on the rising edges of one of eight counting sources. Six of those sources are prescaler taps. The other two are external pin inputs. Each pin can be inverted, and each can be taken either from an externally debounced copy or straight from the raw pin. A raw pin is first divided by two, so the counter advances on every second falling edge of the pin. The counter runs up or down. Its active length can be 4, 6, 8 or 10 bits, and a roll-over interrupt pulse is raised when the active bits reach their terminal value.

Counting is gated by a start input that uses a synchronised arming rule. After start is raised, a falling edge of the selected source must be seen first. Only the rising edge after that edge advances the count. This rule stops a source that is already high from producing a partial first period. A load input presets the count at any time, for example to set the starting value of a down-count time base.

Top module: `tec_counter_top`

## Requirements
- R1: `src_sel_i` picks the counting source: values 0 to 5 select `tap_i[0]` to `tap_i[5]`, 6 selects pin 0 and 7 selects pin 1. Edges on any source that is not selected never change the count.
- R2: With `count_up_i`=1, each counted rising edge adds 1. The full 10-bit register wraps from 0x3FF to 0x000.
- R3: With `count_up_i`=0 (down), each counted rising edge subtracts 1. The full 10-bit register wraps from 0x000 to 0x3FF.
- R4: In up mode, a step whose result has all active bits at one raises the interrupt. `len_sel_i` values 0, 1, 2 and 3 give an active length of 4, 6, 8 and 10 low bits. Bits above the active length are ignored.
- R5: In down mode, a step whose result has all active bits at zero raises the interrupt. The same length encoding as R4 applies.
- R6: For taps and debounced pins, `irq_o` is a single system-clock pulse. It is high in the first cycle in which `count_o` shows the terminal value.
- R7: For a pin with `pin_deb_sel_i` bit = 0, the polarity-corrected raw pin is divided by two. The division starts from its reset phase, and a count happens on every odd-numbered falling edge of the pin once the counter is armed. The interrupt for a terminal step waits for the next rising edge of that pin.
- R8: With `pin_deb_sel_i` bit = 1, the pin's count edges come from `pin_deb_i`, and raw pin activity has no effect. With `pin_inv_i` bit = 1, the pin level is inverted before edge detection.
- R9: After `start_i` rises, no count occurs until a falling edge of the selected source has been seen. The next rising edge after that falling edge is counted.
- R10: With `start_i`=0, the count holds. Lowering start also clears the armed state, so a new falling edge is needed after start is raised again.
- R11: A `load_i` pulse copies `load_val_i` into the count on the next clock edge, with priority over a step. A load never raises the interrupt.
- R12: During and right after reset, `count_o` is 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tap_i | input | 6 | Prescaler tap levels |
| pin_raw_i | input | 2 | Raw external pin levels |
| pin_deb_i | input | 2 | Debounced external pin levels |
| pin_inv_i | input | 2 | Per-pin polarity inversion |
| pin_deb_sel_i | input | 2 | Per-pin choice: 1 debounced, 0 raw divided by two |
| src_sel_i | input | 3 | Counting source select |
| count_up_i | input | 1 | 1 up, 0 down |
| len_sel_i | input | 2 | Active length: 4/6/8/10 bits |
| start_i | input | 1 | Counting enable with arming rule |
| load_i | input | 1 | Preset strobe |
| load_val_i | input | 10 | Preset value |
| count_o | output | 10 | Current count |
| irq_o | output | 1 | Roll-over interrupt pulse |

## Verification
The raw-pin path is the hardest case to reach from the ports. The divide-by-two phase, the arming edge and the deferred interrupt all stack up there, and the divider phase persists across earlier tests. The bench therefore resets the block just before this scenario, so the divider starts from a known phase. It then counts pin pulses one at a time. It checks that the second falling edge only arms the counter, that the third and fifth falling edges count, and that a terminal step raises no interrupt until the following rising edge of the pin.

// File: rtl/tec_pkg.sv
package tec_pkg;

  typedef enum logic [1:0] {
    LEN_4  = 2'd0,
    LEN_6  = 2'd1,
    LEN_8  = 2'd2,
    LEN_10 = 2'd3
  } len_e;

  // number of low bits that take part in terminal detection
  function automatic int active_bits(len_e len);
    return 4 + 2 * int'(len);
  endfunction

endpackage

// File: rtl/tec_src_sel.sv
module tec_src_sel #(
  parameter int N_TAPS = 6,
  parameter int N_PINS = 2,
  parameter int SEL_W  = $clog2(N_TAPS + N_PINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TAPS-1:0] tap_i,
  input  logic [N_PINS-1:0] pin_raw_i,
  input  logic [N_PINS-1:0] pin_deb_i,
  input  logic [N_PINS-1:0] pin_inv_i,
  input  logic [N_PINS-1:0] pin_deb_sel_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              lvl_o,
  output logic              direct_o,
  output logic              pin_rise_o
);

  logic [N_TAPS-1:0] tap_q;
  logic [N_PINS-1:0] raw_q, raw_prev, div_q, deb_q, pin_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tap_q    <= '0;
      raw_q    <= '0;
      raw_prev <= '0;
      div_q    <= '0;
      deb_q    <= '0;
    end else begin
      tap_q    <= tap_i;
      raw_q    <= pin_raw_i ^ pin_inv_i;
      raw_prev <= raw_q;
      deb_q    <= pin_deb_i ^ pin_inv_i;
      for (int p = 0; p < N_PINS; p++) begin
        // divide-by-two: toggle on each falling edge of the corrected pin
        if (raw_prev[p] && !raw_q[p]) div_q[p] <= ~div_q[p];
      end
    end
  end

  always_comb begin
    for (int p = 0; p < N_PINS; p++)
      pin_lvl[p] = pin_deb_sel_i[p] ? deb_q[p] : div_q[p];
  end

  always_comb begin
    lvl_o      = 1'b0;
    direct_o   = 1'b0;
    pin_rise_o = 1'b0;
    for (int t = 0; t < N_TAPS; t++)
      if (sel_i == SEL_W'(t)) lvl_o = tap_q[t];
    for (int p = 0; p < N_PINS; p++)
      if (sel_i == SEL_W'(N_TAPS + p)) begin
        lvl_o      = pin_lvl[p];
        direct_o   = !pin_deb_sel_i[p];
        pin_rise_o = raw_q[p] && !raw_prev[p];
      end
  end

  // R7: the divided level only moves right after a falling edge of its pin
  a_r7_div_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q[0] || !raw_prev[0]) |=> $stable(div_q[0]));

endmodule

// File: rtl/tec_start_sync.sv
module tec_start_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic start_i,
  output logic step_o,
  output logic armed_o
);

  logic lvl_prev;
  logic rise_w, fall_w;

  assign rise_w = lvl_i && !lvl_prev;
  assign fall_w = !lvl_i && lvl_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_prev <= 1'b0;
      armed_o  <= 1'b0;
    end else begin
      lvl_prev <= lvl_i;
      if (!start_i)    armed_o <= 1'b0;
      else if (fall_w) armed_o <= 1'b1;
    end
  end

  assign step_o = start_i && armed_o && rise_w;

  // R10: dropping start forgets the latched falling edge
  a_r10_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !armed_o);

  // R9: arming only follows a falling edge seen while started
  a_r9_arm_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_o && !(start_i && fall_w)) |=> !armed_o);

endmodule

// File: rtl/tec_core.sv
module tec_core #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             up_i,
  input  tec_pkg::len_e    len_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             direct_i,
  input  logic             pin_rise_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);

  function automatic logic [CNT_W-1:0] len_mask(tec_pkg::len_e len);
    int aw;
    aw = tec_pkg::active_bits(len);
    if (aw >= CNT_W) return '1;
    return CNT_W'((32'd1 << aw) - 32'd1);
  endfunction

  function automatic logic is_terminal(logic [CNT_W-1:0] v, logic up,
                                       tec_pkg::len_e len);
    logic [CNT_W-1:0] m;
    m = len_mask(len);
    return up ? ((v & m) == m) : ((v & m) == '0);
  endfunction

  function automatic logic [CNT_W-1:0] next_val(logic [CNT_W-1:0] v, logic up);
    return up ? v + CNT_W'(1) : v - CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] nxt_w;
  logic             hit_w;
  logic             pend_q;

  assign nxt_w = next_val(count_o, up_i);
  assign hit_w = step_i && !load_i && is_terminal(nxt_w, up_i, len_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_o <= '0;
      irq_o   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (load_i)      count_o <= load_val_i;
      else if (step_i) count_o <= nxt_w;

      irq_o <= (hit_w && !direct_i) || (pend_q && pin_rise_i && direct_i);

      if (load_i)                  pend_q <= 1'b0;
      else if (hit_w && direct_i)  pend_q <= 1'b1;
      else if (pend_q && pin_rise_i) pend_q <= 1'b0;
    end
  end

  // R2: up step adds one
  a_r2_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && up_i) |=> count_o == CNT_W'($past(count_o) + CNT_W'(1)));

  // R3: down step subtracts one
  a_r3_down_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && !up_i) |=> count_o == CNT_W'($past(count_o) - CNT_W'(1)));

  // R10: no step and no load means the count holds
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> $stable(count_o));

  // R11: load wins and lands on the next edge
  a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> count_o == $past(load_val_i));

  // R6: the interrupt never lasts two cycles
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  // R4 / R5: synchronous interrupt only shows with a terminal count
  a_r4_r5_irq_terminal: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !direct_i && $stable(up_i) && $stable(len_i))
      |-> is_terminal(count_o, up_i, len_i));

endmodule

// File: rtl/tec_counter_top.sv
module tec_counter_top #(
  parameter int CNT_W  = 10,
  parameter int N_TAPS = 6,
  parameter int N_PINS = 2,
  parameter int SEL_W  = $clog2(N_TAPS + N_PINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TAPS-1:0] tap_i,
  input  logic [N_PINS-1:0] pin_raw_i,
  input  logic [N_PINS-1:0] pin_deb_i,
  input  logic [N_PINS-1:0] pin_inv_i,
  input  logic [N_PINS-1:0] pin_deb_sel_i,
  input  logic [SEL_W-1:0]  src_sel_i,
  input  logic              count_up_i,
  input  logic [1:0]        len_sel_i,
  input  logic              start_i,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  load_val_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              irq_o
);

  logic sel_lvl, direct_w, pin_rise_w, step_w, armed_w;
  tec_pkg::len_e len_w;

  assign len_w = tec_pkg::len_e'(len_sel_i);

  tec_src_sel #(.N_TAPS(N_TAPS), .N_PINS(N_PINS), .SEL_W(SEL_W)) u_src (
    .clk           (clk),
    .rst_n         (rst_n),
    .tap_i         (tap_i),
    .pin_raw_i     (pin_raw_i),
    .pin_deb_i     (pin_deb_i),
    .pin_inv_i     (pin_inv_i),
    .pin_deb_sel_i (pin_deb_sel_i),
    .sel_i         (src_sel_i),
    .lvl_o         (sel_lvl),
    .direct_o      (direct_w),
    .pin_rise_o    (pin_rise_w)
  );

  tec_start_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl_i   (sel_lvl),
    .start_i (start_i),
    .step_o  (step_w),
    .armed_o (armed_w)
  );

  tec_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (step_w),
    .up_i       (count_up_i),
    .len_i      (len_w),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .direct_i   (direct_w),
    .pin_rise_i (pin_rise_w),
    .count_o    (count_o),
    .irq_o      (irq_o)
  );

  // R9: a step is only possible once armed
  a_r9_step_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_w && !load_i) |=> $stable(count_o));

endmodule

// File: tb/tb_tec_counter_top.sv
`timescale 1ns/1ps
module tb_tec_counter_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] tap;
  logic [1:0] pin_raw, pin_deb, pin_inv, pin_deb_sel;
  logic [2:0] src_sel;
  logic       count_up;
  logic [1:0] len_sel;
  logic       start, load;
  logic [9:0] load_val;
  logic [9:0] count;
  logic       irq;

  int errors = 0;
  int checks = 0;
  int irq_total = 0;
  logic [9:0] last_irq_cnt = '0;

  always #2.5 clk = ~clk;

  tec_counter_top dut (
    .clk(clk), .rst_n(rst_n), .tap_i(tap), .pin_raw_i(pin_raw),
    .pin_deb_i(pin_deb), .pin_inv_i(pin_inv), .pin_deb_sel_i(pin_deb_sel),
    .src_sel_i(src_sel), .count_up_i(count_up), .len_sel_i(len_sel),
    .start_i(start), .load_i(load), .load_val_i(load_val),
    .count_o(count), .irq_o(irq)
  );

  always @(negedge clk) if (irq) begin
    irq_total++;
    last_irq_cnt = count;
  end

  typedef struct packed {
    logic       up;
    logic [1:0] len;
    logic [9:0] ld;
    logic [4:0] pulses;
    logic [9:0] exp_cnt;
    logic [1:0] exp_irq;
  } vec_t;

  localparam vec_t VEC [0:10] = '{
    '{1'b1, 2'd0, 10'h00C, 5'd5,  10'h011, 2'd1},
    '{1'b1, 2'd1, 10'h03D, 5'd3,  10'h040, 2'd1},
    '{1'b1, 2'd2, 10'h0FE, 5'd2,  10'h100, 2'd1},
    '{1'b1, 2'd3, 10'h3FD, 5'd4,  10'h001, 2'd1},
    '{1'b0, 2'd0, 10'h013, 5'd4,  10'h00F, 2'd1},
    '{1'b0, 2'd1, 10'h042, 5'd3,  10'h03F, 2'd1},
    '{1'b0, 2'd2, 10'h101, 5'd2,  10'h0FF, 2'd1},
    '{1'b0, 2'd3, 10'h002, 5'd3,  10'h3FF, 2'd1},
    '{1'b1, 2'd0, 10'h0F0, 5'd14, 10'h0FE, 2'd0},
    '{1'b0, 2'd3, 10'h100, 5'd3,  10'h0FD, 2'd0},
    '{1'b1, 2'd3, 10'h0FE, 5'd2,  10'h100, 2'd0}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(2);
  endtask

  task automatic do_load(logic [9:0] v);
    load_val = v;
    load = 1'b1;
    idle(1);
    load = 1'b0;
    idle(1);
  endtask

  task automatic pulse_tap(int t);
    tap[t] = 1'b1; idle(4);
    tap[t] = 1'b0; idle(4);
  endtask

  task automatic pulse_deb0();   // inverted debounced pin: drive low to rise
    pin_deb[0] = 1'b0; idle(4);
    pin_deb[0] = 1'b1; idle(4);
  endtask

  task automatic pulse_raw1();
    pin_raw[1] = 1'b1; idle(4);
    pin_raw[1] = 1'b0; idle(4);
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base;
    logic [9:0] c0;
    tap = '0; pin_raw = '0; pin_deb = '0; pin_inv = '0; pin_deb_sel = '0;
    src_sel = '0; count_up = 1'b0; len_sel = '0; start = 1'b0;
    load = 1'b0; load_val = '0;
    rst_n = 1'b0;
    idle(3);
    chk("R12 count in reset", 32'(count), 32'h0);
    chk("R12 irq in reset", 32'(irq), 32'h0);
    rst_n = 1'b1;
    idle(2);
    chk("R12 count after reset", 32'(count), 32'h0);

    // table of terminal-detection vectors, tap rotates through all six
    for (int i = 0; i < 11; i++) begin
      int t;
      t = i % 6;
      src_sel  = 3'(t);
      count_up = VEC[i].up;
      len_sel  = VEC[i].len;
      do_load(VEC[i].ld);
      base = irq_total;
      start = 1'b1;
      idle(1);
      pulse_tap(t);                       // arming pulse, not counted (R9)
      for (int k = 0; k < int'(VEC[i].pulses); k++) pulse_tap(t);
      chk(VEC[i].up ? "R2 R4 R1 count" : "R3 R5 R1 count",
          32'(count), 32'(VEC[i].exp_cnt));
      chk(VEC[i].up ? "R4 irq count" : "R5 irq count",
          32'(irq_total - base), 32'(VEC[i].exp_irq));
      if (i == 0) chk("R6 count shown with irq", 32'(last_irq_cnt), 32'h00F);
      if (i == 7) chk("R6 count shown with irq", 32'(last_irq_cnt), 32'h000);
      start = 1'b0;
      idle(1);
    end

    // R1: other sources are ignored
    src_sel = 3'd3; count_up = 1'b1; len_sel = 2'd3;
    do_load(10'h020);
    start = 1'b1; idle(1);
    pulse_tap(3);
    for (int t = 0; t < 6; t++) if (t != 3) begin
      pulse_tap(t); pulse_tap(t);
    end
    pin_raw = 2'b11; pin_deb = 2'b11; idle(4);
    pin_raw = 2'b00; pin_deb = 2'b00; idle(4);
    chk("R1 unselected sources ignored", 32'(count), 32'h020);
    pulse_tap(3);
    chk("R1 selected tap counts", 32'(count), 32'h021);

    // R10: stop freezes and disarms
    start = 1'b0; idle(1);
    pulse_tap(3); pulse_tap(3);
    chk("R10 frozen while stopped", 32'(count), 32'h021);
    start = 1'b1; idle(1);
    pulse_tap(3);
    chk("R10 re-arm needed", 32'(count), 32'h021);
    pulse_tap(3);
    chk("R10 counts after re-arm", 32'(count), 32'h022);
    start = 1'b0; idle(1);

    // R9: start raised while source is high
    src_sel = 3'd0;
    do_load(10'h000);
    tap[0] = 1'b1; idle(4);
    start = 1'b1; idle(6);
    chk("R9 no count while high", 32'(count), 32'h000);
    tap[0] = 1'b0; idle(4);
    chk("R9 fall only arms", 32'(count), 32'h000);
    tap[0] = 1'b1; idle(4);
    chk("R9 next rise counts", 32'(count), 32'h001);
    tap[0] = 1'b0; idle(4);

    // R11: load while running, terminal value, no irq
    base = irq_total;
    do_load(10'h3FF);
    chk("R11 load value", 32'(count), 32'h3FF);
    idle(3);
    chk("R11 no irq from load", 32'(irq_total - base), 32'h0);
    start = 1'b0; idle(1);

    // R8: debounced, inverted pin 0; raw pin activity ignored
    pin_deb_sel = 2'b01; pin_inv = 2'b01; pin_deb[0] = 1'b1;
    src_sel = 3'd6; count_up = 1'b1;
    idle(4);
    do_load(10'h000);
    start = 1'b1; idle(1);
    pulse_deb0();
    pulse_deb0();
    pin_raw[0] = 1'b1; idle(4); pin_raw[0] = 1'b0; idle(4);
    pin_raw[0] = 1'b1; idle(4); pin_raw[0] = 1'b0; idle(4);
    pulse_deb0();
    chk("R8 debounced inverted pin", 32'(count), 32'h002);
    start = 1'b0; idle(1);

    // R7: raw pin 1, divided by two, deferred irq
    pin_deb_sel = 2'b00; pin_inv = 2'b00; pin_raw = 2'b00; pin_deb = 2'b00;
    src_sel = 3'd7; count_up = 1'b0; len_sel = 2'd3;
    do_reset();
    do_load(10'h002);
    base = irq_total;
    start = 1'b1; idle(1);
    pulse_raw1(); pulse_raw1();
    chk("R7 first two falls do not count", 32'(count), 32'h002);
    pulse_raw1();
    chk("R7 third fall counts", 32'(count), 32'h001);
    pulse_raw1();
    chk("R7 even fall ignored", 32'(count), 32'h001);
    pulse_raw1();
    c0 = count;
    chk("R7 fifth fall counts", 32'(c0), 32'h000);
    chk("R7 irq held until pin rise", 32'(irq_total - base), 32'h0);
    pin_raw[1] = 1'b1; idle(4);
    chk("R7 irq on pin rise", 32'(irq_total - base), 32'h1);
    pin_raw[1] = 1'b0; idle(4);
    start = 1'b0; idle(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule